// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block sits between a device that can only issue 32-bit addresses and a system address space that is 40 bits wide. A programmable window (the aperture) is carved out of the device's address space. Every device address that lands inside the window is split into a page number and a byte offset. The page number is relative to the window and selects one entry of a remap table. The entry supplies a 28-bit system page frame, so pages that are scattered across system memory, including pages above 4 GB, appear to the device as one contiguous range. Addresses outside the window leave the block unchanged, widened with zeros. The block checks no permissions; it only rewrites addresses.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. Each result carries one of three kinds: pass-through, hit or error. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A result is consumed on a clock edge where `rsp_valid` and `rsp_ready` are both high. While a result waits with `rsp_ready` low, the pipeline freezes and `req_ready` stays low, so no request is dropped or reordered. A plain write-only configuration port sets the window and fills the table.

Top module: `aperture_remap`

## Requirements
- R1: A request outside the window, or any request while the window is disabled, returns kind 0 (pass) with `rsp_addr` equal to `req_addr` zero-extended to 40 bits.
- R2: A request inside the window whose table entry is valid returns kind 1 (hit) with `rsp_addr[39:12]` equal to the entry's frame and `rsp_addr[11:0]` equal to `req_addr[11:0]`.
- R3: A request inside the window whose table entry is invalid returns kind 2 (error) with `rsp_addr` equal to zero. Kind 3 is never produced.
- R4: The window holds 2^(TBL_IDX_W-3+sz) pages of 4 KB. Here sz is `cfg_wdata[1:0]`, `cfg_wdata[2]` is the enable bit, and `cfg_wdata[31:12]` is the base. These fields are written with `cfg_sel`=0. Base bits below the window size are ignored. The table index is the page number relative to the window.
- R5: After reset the window is disabled, so every request passes through as in R1.
- R6: A request taken at edge k produces `rsp_valid` at edge k+2 when `req_ready` is high at edge k+1.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_addr` and `rsp_kind` hold steady and `req_ready` is low. Results leave in request order.
- R8: A window or table write takes effect only for requests taken at later edges. A request taken on the same edge as a write sees the old setting. A table write uses `cfg_sel`=1, the entry index `cfg_idx`, the valid bit `cfg_wdata[28]` and the frame `cfg_wdata[27:0]`.
- R9: After reset `rsp_valid` is low, `req_ready` is high, and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Device address offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Device address |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 40 | System address |
| rsp_kind | output | 2 | 0 pass, 1 hit, 2 error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 window register, 1 table entry |
| cfg_idx | input | TBL_IDX_W | Table entry index |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
Two pairs of functions can land on the same edge. The first pair is a configuration write and a request being taken. The bench drives a table write together with a request that indexes the written entry, and a window disable together with an in-window request. It expects the old answer for that request and the new answer for the next one. The second pair is back-pressure and a newly offered request. A randomly toggling `rsp_ready` freezes the pipeline while requests keep arriving. A scoreboard checks that every result arrives in order and that a stalled result never changes.

// File: rtl/apr_pkg.sv
package apr_pkg;
  typedef enum logic [1:0] {
    RK_PASS = 2'd0,
    RK_HIT  = 2'd1,
    RK_ERR  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/apr_window_cfg.sv
module apr_window_cfg #(
  parameter int IN_AW     = 32,
  parameter int PAGE_BITS = 12,
  parameter int TBL_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IN_AW-1:0]     wr_data,
  input  logic [IN_AW-1:0]     addr,
  output logic                 in_win,
  output logic [TBL_IDX_W-1:0] page_idx
);
  localparam int BASE_W    = IN_AW - PAGE_BITS;
  localparam int MIN_PG_LG = TBL_IDX_W - 3;

  logic [BASE_W-1:0]    base_q;
  logic                 en_q;
  logic [1:0]           sz_q;
  logic [7:0]           pg_lg;
  logic [7:0]           ap_lg;
  logic [IN_AW-1:0]     win_mask;
  logic [IN_AW-1:0]     base_full;
  logic [TBL_IDX_W-1:0] idx_ones;
  logic [TBL_IDX_W-1:0] pg_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      sz_q   <= 2'd0;
    end else if (wr_en) begin
      base_q <= wr_data[IN_AW-1:PAGE_BITS];
      en_q   <= wr_data[2];
      sz_q   <= wr_data[1:0];
    end
  end

  always_comb begin
    pg_lg     = 8'(MIN_PG_LG) + {6'd0, sz_q};
    ap_lg     = pg_lg + 8'(PAGE_BITS);
    win_mask  = {IN_AW{1'b1}} << ap_lg;
    base_full = {base_q, {PAGE_BITS{1'b0}}};
    in_win    = en_q && (((addr ^ base_full) & win_mask) == '0);
    idx_ones  = '1;
    pg_mask   = ~(idx_ones << pg_lg);
    page_idx  = addr[PAGE_BITS +: TBL_IDX_W] & pg_mask;
  end

  // R5: window stays closed from reset until an enabling write arrives
  assert_closed_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> !in_win);
endmodule

// File: rtl/apr_page_table.sv
module apr_page_table #(
  parameter int PFN_W     = 28,
  parameter int TBL_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TBL_IDX_W-1:0] wr_idx,
  input  logic                 wr_vld,
  input  logic [PFN_W-1:0]     wr_pfn,
  input  logic                 rd_en,
  input  logic [TBL_IDX_W-1:0] rd_idx,
  output logic                 rd_vld,
  output logic [PFN_W-1:0]     rd_pfn
);
  localparam int DEPTH = 1 << TBL_IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [PFN_W-1:0] pfn_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (!rst_n)
        vld_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == TBL_IDX_W'(g)))
        vld_q[g] <= wr_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pfn_mem[wr_idx] <= wr_pfn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_pfn <= '0;
    end else if (rd_en) begin
      rd_vld <= vld_q[rd_idx];
      rd_pfn <= pfn_mem[rd_idx];
    end
  end

  // R8: a read colliding with a write to the same entry returns the old valid bit
  assert_read_before_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && (rd_idx == wr_idx)) |=> (rd_vld == $past(vld_q[rd_idx])));
endmodule

// File: rtl/apr_resp_stage.sv
module apr_resp_stage
  import apr_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 28
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        s1_v,
  input  logic [IN_AW-1:0]            s1_addr,
  input  logic                        s1_in_win,
  input  logic                        tbl_vld,
  input  logic [PFN_W-1:0]            tbl_pfn,
  output logic                        rsp_valid,
  output logic [PFN_W+PAGE_BITS-1:0]  rsp_addr,
  output rsp_kind_e                   rsp_kind
);
  localparam int OUT_AW = PFN_W + PAGE_BITS;

  logic [OUT_AW-1:0] nxt_addr;
  rsp_kind_e         nxt_kind;

  always_comb begin
    if (!s1_in_win) begin
      nxt_addr = OUT_AW'(s1_addr);
      nxt_kind = RK_PASS;
    end else if (tbl_vld) begin
      nxt_addr = {tbl_pfn, s1_addr[PAGE_BITS-1:0]};
      nxt_kind = RK_HIT;
    end else begin
      nxt_addr = '0;
      nxt_kind = RK_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= RK_PASS;
    end else if (adv) begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_addr <= nxt_addr;
        rsp_kind <= nxt_kind;
      end
    end
  end

  // R3: error results carry a zero address
  assert_err_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RK_ERR) |-> (rsp_addr == '0));
  // R3: the unused kind code never leaves the block
  assert_no_bad_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3));
  // R1: pass-through results never set bits above the device address width
  assert_pass_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RK_PASS) |-> ((rsp_addr >> IN_AW) == '0));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import apr_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 28,
  parameter int TBL_IDX_W = 8,
  localparam int OUT_AW   = PFN_W + PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IN_AW-1:0]     req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [OUT_AW-1:0]    rsp_addr,
  output logic [1:0]           rsp_kind,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [TBL_IDX_W-1:0] cfg_idx,
  input  logic [IN_AW-1:0]     cfg_wdata
);
  logic                 adv;
  logic                 acc;
  logic                 in_win;
  logic [TBL_IDX_W-1:0] page_idx;
  logic                 s1_v;
  logic [IN_AW-1:0]     s1_addr;
  logic                 s1_in_win;
  logic                 tbl_vld;
  logic [PFN_W-1:0]     tbl_pfn;
  rsp_kind_e            kind_e;

  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;
  assign acc       = req_valid && adv;
  assign rsp_kind  = kind_e;

  apr_window_cfg #(.IN_AW(IN_AW), .PAGE_BITS(PAGE_BITS), .TBL_IDX_W(TBL_IDX_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && !cfg_sel),
    .wr_data  (cfg_wdata),
    .addr     (req_addr),
    .in_win   (in_win),
    .page_idx (page_idx)
  );

  apr_page_table #(.PFN_W(PFN_W), .TBL_IDX_W(TBL_IDX_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we && cfg_sel),
    .wr_idx (cfg_idx),
    .wr_vld (cfg_wdata[PFN_W]),
    .wr_pfn (cfg_wdata[PFN_W-1:0]),
    .rd_en  (acc),
    .rd_idx (page_idx),
    .rd_vld (tbl_vld),
    .rd_pfn (tbl_pfn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_addr   <= '0;
      s1_in_win <= 1'b0;
    end else if (adv) begin
      s1_v <= acc;
      if (acc) begin
        s1_addr   <= req_addr;
        s1_in_win <= in_win;
      end
    end
  end

  apr_resp_stage #(.IN_AW(IN_AW), .PAGE_BITS(PAGE_BITS), .PFN_W(PFN_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .s1_v      (s1_v),
    .s1_addr   (s1_addr),
    .s1_in_win (s1_in_win),
    .tbl_vld   (tbl_vld),
    .tbl_pfn   (tbl_pfn),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_kind  (kind_e)
  );

  // R7: a stalled result is frozen
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_kind)));
  // R6: two-edge latency when the pipeline keeps moving
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##1 req_ready |=> rsp_valid);
endmodule

// File: tb/test_aperture_remap.sv
`timescale 1ns/1ps
module test_aperture_remap;
  typedef struct {
    logic [39:0] a;
    logic [1:0]  k;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [39:0] rsp_addr;
  logic [1:0]  rsp_kind;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit bp_mode = 0;
  exp_t sb[$];

  logic [31:0] m_base = '0;
  bit          m_en = 0;
  int          m_sz = 0;
  bit          m_v   [256];
  logic [27:0] m_pfn [256];

  always #2.5 clk = ~clk;

  aperture_remap i_aperture_remap (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic void model(input logic [31:0] a, output logic [39:0] ea, output logic [1:0] ek);
    logic [31:0] mask;
    int idx;
    mask = 32'hFFFF_FFFF << (17 + m_sz);
    if (m_en && (((a ^ m_base) & mask) == 0)) begin
      idx = int'((a >> 12) & ((32'd1 << (5 + m_sz)) - 1));
      if (m_v[idx]) begin ea = {m_pfn[idx], a[11:0]}; ek = 2'd1; end
      else begin ea = '0; ek = 2'd2; end
    end else begin
      ea = {8'h00, a}; ek = 2'd0;
    end
  endfunction

  function automatic string kind_tag(input logic [1:0] k);
    if (k == 2'd0) return "R1";
    if (k == 2'd1) return "R2";
    return "R3";
  endfunction

  task automatic push_exp(input logic [31:0] a, input string tag);
    exp_t e;
    model(a, e.a, e.k);
    e.tag = (tag == "") ? kind_tag(e.k) : tag;
    sb.push_back(e);
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    bit ok;
    push_exp(a, tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    forever begin
      #1 ok = req_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_win(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = d;
    @(posedge clk);
    m_base = d & 32'hFFFF_F000; m_en = d[2]; m_sz = int'(d[1:0]);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_ent(input int idx, input bit v, input logic [27:0] pfn);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_idx = 8'(idx); cfg_wdata = {3'b000, v, pfn};
    @(posedge clk);
    m_v[idx] = v; m_pfn[idx] = pfn;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // back-pressure generator
  always @(negedge clk) rsp_ready = bp_mode ? 1'($urandom % 2) : 1'b1;

  // scoreboard monitor
  bit          prev_stall = 0;
  logic [39:0] prev_addr;
  logic [1:0]  prev_kind;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (prev_stall)
          check(rsp_valid && rsp_addr == prev_addr && rsp_kind == prev_kind, "R7 stalled result changed",
                {rsp_valid, 21'd0, rsp_kind, rsp_addr}, {1'b1, 21'd0, prev_kind, prev_addr});
        if (rsp_valid && rsp_ready) begin
          if (sb.size() == 0) check(1'b0, "R7 unexpected result", 64'(rsp_addr), 64'd0);
          else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_addr == e.a && rsp_kind == e.k, e.tag, {22'd0, rsp_kind, rsp_addr}, {22'd0, e.k, e.a});
          end
        end
        prev_stall = rsp_valid && !rsp_ready;
        prev_addr  = rsp_addr;
        prev_kind  = rsp_kind;
      end
    end
  end

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_v[i] = 0; m_pfn[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 idle after reset",
          {62'd0, rsp_valid, req_ready}, 64'd1);

    // R5: closed window passes everything
    send(32'h8000_0123, "R5");
    send(32'h0000_1000, "R5");
    drain();

    // window at 0x8000_0000, 32 pages, enabled; reset table still invalid (R9)
    cfg_win(32'h8000_0004);
    send(32'h8000_3010, "R9 entry invalid after reset");
    drain();

    cfg_ent(0, 1, 28'h123_4567);
    cfg_ent(5, 1, 28'hFFF_FFFF);
    cfg_ent(31, 1, 28'h010_0000);
    cfg_ent(3, 0, 28'h0AB_CDEF);
    send(32'h8000_0ABC, "R2");
    send(32'h8000_5FFF, "R2");
    send(32'h8001_F004, "R2 above 4GB");
    send(32'h8000_3444, "R3");
    send(32'h7FFF_FFFF, "R1");
    send(32'h8002_0000, "R1 just past window");
    send(32'hFFFF_FFFF, "R1");
    drain();

    // R4: size code 1 doubles the window; base low bits ignored
    cfg_win(32'h8001_0005);
    send(32'h8002_0000, "R4 page 32 now inside");
    cfg_ent(32, 1, 28'h000_0042);
    send(32'h8002_0777, "R4 page 32 mapped");
    send(32'h8000_0010, "R4 base low bits ignored");
    send(32'h8004_0000, "R4 beyond 64 pages");
    drain();

    // R6: latency with the consumer always ready
    @(negedge clk);
    push_exp(32'h8000_0001, "R6");
    req_valid = 1'b1; req_addr = 32'h8000_0001;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check(rsp_valid == 1'b0, "R6 early result", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    #1 check(rsp_valid == 1'b1, "R6 result after two edges", 64'(rsp_valid), 64'd1);
    drain();

    // R8: table write on the same edge as a request to that entry
    @(negedge clk);
    push_exp(32'h8000_7ABC, "R8 same-edge old entry");
    req_valid = 1'b1; req_addr = 32'h8000_7ABC;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_idx = 8'd7; cfg_wdata = {3'b000, 1'b1, 28'h765_4321};
    @(posedge clk);
    m_v[7] = 1; m_pfn[7] = 28'h765_4321;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    send(32'h8000_7ABC, "R8 later sees new entry");
    drain();

    // R8: window disabled on the same edge as an in-window request
    @(negedge clk);
    push_exp(32'h8000_0200, "R8 same-edge old window");
    req_valid = 1'b1; req_addr = 32'h8000_0200;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h8000_0001;
    @(posedge clk);
    m_en = 0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    send(32'h8000_0200, "R8 later sees disabled window");
    drain();

    // stress under back-pressure
    cfg_win(32'h4000_0005);
    for (int i = 0; i < 64; i++) cfg_ent(i, 1'($urandom % 4 != 0), 28'($urandom));
    bp_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      if ($urandom % 3 != 0) a = 32'h4000_0000 | (($urandom % 64) << 12) | ($urandom % 4096);
      else a = $urandom;
      send(a, "");
    end
    drain();
    bp_mode = 0;
    check(sb.size() == 0, "R7 scoreboard drained", 64'(sb.size()), 64'd0);
    summary();
  end
endmodule